// File: doc/BRIEF.md
# HDLC Frame Transmitter with Block FIFO

This block serialises HDLC frames onto a single output line. A microcontroller loads frame bytes into a byte-wide FIFO one block at a time. It then issues one-cycle commands to push the block out. A transmit command commits the bytes now in the FIFO and starts a frame, or continues the one in progress. A message-end command commits the bytes and marks them as the tail of the frame. A reset command aborts any frame and empties the FIFO.

The line advances one bit per pulse of a bit-clock enable. When no frame is active the line carries back-to-back flags. A frame goes out as:

- an opening flag;
- the payload, least significant bit first, with a zero inserted after every run of five ones;
- an optional 16-bit frame check sequence;
- a closing flag.

When the last byte of a continuing block moves into the shifter, a one-cycle interrupt asks software for the next block. If the FIFO runs dry before message end, the frame is aborted and an underrun status is raised. A raw mode sends the committed bytes verbatim, with no flags, stuffing or check sequence.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: After reset `txd` is 1, and `pool_irq` and `underrun` are 0. Whenever no frame is active and `cfg_raw` is 0, the line repeats the flag 0x7E, one flag per 8 bit periods.
- R2: A frame is sent as follows:
  - an opening flag 0x7E;
  - every committed data byte, least significant bit first;
  - when enabled, the check sequence, low byte first. It is CRC-16 with polynomial 0x1021 processed bit-reflected (0x8408), preset 0xFFFF, computed over the data bits and then inverted, each byte sent least significant bit first;
  - a closing flag 0x7E.
- R3: With `cfg_no_crc` = 1 no check sequence is sent, and the closing flag follows the last data byte.
- R4: Outside raw mode, a 0 is inserted after every five consecutive 1s of data or check sequence, and flags are never stuffed. Payloads of all-ones bytes or flag-valued bytes decode unchanged.
- R5: The FIFO accepts at most 16 bytes when `cfg_big_blk` = 0 and at most 32 bytes when it is 1. Writes while it is full are dropped.
- R6: `pool_irq` pulses for exactly one clock when the last byte of a block committed by `cmd_xmit` is taken into the shifter. A block committed by `cmd_end` raises no pulse.
- R7: Bytes written after a pool interrupt and committed by another command continue the same frame, so only one frame appears on the line.
- R8: If a frame needs a byte when none is committed and no message end was given, at least seven 1s are sent and `underrun` is set. `underrun` stays set until `cmd_reset`.
- R9: `cmd_reset` does the following:
  - clears `underrun` in the next cycle;
  - discards all FIFO contents;
  - aborts an active frame with at least seven 1s, after which the line returns to flags.
- R10: With `cfg_raw` = 1 the line idles at 1 and committed bytes are sent least significant bit first, with no flag, no stuffing and no check sequence.
- R11: `txd` changes only in the clock following a cycle with `bit_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse that advances the line by one bit |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| cmd_xmit | input | 1 | Commit FIFO contents; start or continue a frame |
| cmd_end | input | 1 | Commit FIFO contents as the frame's final block |
| cmd_reset | input | 1 | Abort transmission and empty the FIFO |
| cfg_big_blk | input | 1 | 0: 16-byte block, 1: 32-byte block |
| cfg_no_crc | input | 1 | 1: omit the check sequence |
| cfg_raw | input | 1 | 1: raw mode without flags, stuffing or check sequence |
| txd | output | 1 | Serial line output |
| pool_irq | output | 1 | One-cycle request for the next block |
| underrun | output | 1 | Sticky underrun status |

## Verification
The bench builds the block with its default block sizes of 16 and 32 bytes. Both limits are therefore reached through `cfg_big_blk`, including the dropped writes past a full block. A bit-enable every eight clocks leaves time to refill a block after the pool interrupt, which brings the two-block continued frame within reach. Withholding that refill provokes the underrun abort. A decoder in the bench destuffs the line and checks the check sequence, which covers payloads that would mimic flags or long runs of ones.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ABORT_BYTE = 8'hFF;
    localparam logic [7:0]  MARK_BYTE  = 8'hFF;   // raw-mode idle pattern
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408; // 0x1021 bit-reflected
    localparam int          STUFF_RUN  = 5;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_OPEN,
        TX_DATA,
        TX_FCS,
        TX_CLOSE,
        TX_ABORT
    } tx_state_e;

    function automatic logic [15:0] crc_shift(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = {1'b0, c[15:1]};
        if (c[0] ^ b) r = r ^ CRC_POLY_R;
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int SMALL_BLK = 16,
    parameter int BIG_BLK   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       big_blk,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       commit,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       avail,
    output logic       last
);
    localparam int DEPTH = BIG_BLK;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] LIM_SMALL = LW'(SMALL_BLK);
    localparam logic [LW-1:0] LIM_BIG   = LW'(BIG_BLK);
    localparam logic [AW-1:0] PTR_TOP   = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] level;
        logic [LW-1:0] held;   // committed bytes not yet popped
    } fifo_t;

    fifo_t q, n;
    logic [7:0] mem [DEPTH];
    logic [LW-1:0] lim;
    logic [LW-1:0] pop_w;
    logic [LW-1:0] push_w;
    logic push;

    always_comb begin
        n      = q;
        lim    = big_blk ? LIM_BIG : LIM_SMALL;
        push   = wr_en && !clear && (q.level < lim);
        pop_w  = {{(LW-1){1'b0}}, pop};
        push_w = {{(LW-1){1'b0}}, push};
        if (clear) begin
            n = '0;
        end else begin
            if (push) n.wptr = (q.wptr == PTR_TOP) ? '0 : q.wptr + 1'b1;
            if (pop)  n.rptr = (q.rptr == PTR_TOP) ? '0 : q.rptr + 1'b1;
            n.level = q.level + push_w - pop_w;
            n.held  = commit ? (q.level - pop_w) : (q.held - pop_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wptr] <= wr_data;
    end

    assign rd_data = mem[q.rptr];
    assign avail   = (q.held != '0);
    assign last    = (q.held == LW'(1));

endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       cmd_xmit,
    input  logic       cmd_end,
    input  logic       cmd_reset,
    input  logic       cfg_no_crc,
    input  logic       cfg_raw,
    input  logic [7:0] rd_data,
    input  logic       avail,
    input  logic       last,
    output logic       pop,
    output logic       txd,
    output logic       irq,
    output logic       underrun
);
    typedef struct packed {
        tx_state_e   st;
        logic [7:0]  sh;
        logic [2:0]  bitn;
        logic [2:0]  ones;
        logic [15:0] crc;
        logic        fcs_hi;
        logic        go;
        logic        endm;
        logic        txd;
        logic        undr;
        logic        irq;
    } ser_t;

    ser_t q, n;
    logic want;
    logic stuffing;
    logic [7:0] idle_byte;

    always_comb begin
        n         = q;
        n.irq     = 1'b0;
        pop       = 1'b0;
        want      = 1'b0;
        idle_byte = cfg_raw ? MARK_BYTE : FLAG_BYTE;
        stuffing  = !cfg_raw && (q.st == TX_DATA || q.st == TX_FCS);
        if (cmd_reset) begin
            n.go   = 1'b0;
            n.endm = 1'b0;
            n.undr = 1'b0;
            n.ones = 3'd0;
            if (q.st != TX_IDLE) begin
                n.st     = TX_ABORT;
                n.sh     = ABORT_BYTE;
                n.bitn   = 3'd0;
                n.fcs_hi = 1'b0;
            end
        end else begin
            if (cmd_xmit || cmd_end) n.go = 1'b1;
            if (cmd_end)             n.endm = 1'b1;
            if (bit_en) begin
                if (q.ones == 3'(STUFF_RUN)) begin
                    n.txd  = 1'b0;
                    n.ones = 3'd0;
                end else begin
                    n.txd  = q.sh[0];
                    n.sh   = {1'b0, q.sh[7:1]};
                    n.bitn = q.bitn + 3'd1;
                    n.ones = (stuffing && q.sh[0]) ? q.ones + 3'd1 : 3'd0;
                    if (q.st == TX_DATA) n.crc = crc_shift(q.crc, q.sh[0]);
                    if (q.bitn == 3'd7) begin
                        case (q.st)
                            TX_IDLE: begin
                                if (q.go && avail) begin
                                    if (cfg_raw) begin
                                        want = 1'b1;
                                    end else begin
                                        n.st = TX_OPEN;
                                        n.sh = FLAG_BYTE;
                                    end
                                end else begin
                                    n.sh = idle_byte;
                                end
                            end
                            TX_OPEN: begin
                                n.crc = CRC_INIT;
                                want  = 1'b1;
                            end
                            TX_DATA: want = 1'b1;
                            TX_FCS: begin
                                if (!q.fcs_hi) begin
                                    n.sh     = ~q.crc[15:8];
                                    n.fcs_hi = 1'b1;
                                end else begin
                                    n.st = TX_CLOSE;
                                    n.sh = FLAG_BYTE;
                                end
                            end
                            default: begin
                                n.st     = TX_IDLE;
                                n.sh     = idle_byte;
                                n.go     = 1'b0;
                                n.endm   = 1'b0;
                                n.fcs_hi = 1'b0;
                            end
                        endcase
                        if (want) begin
                            if (avail) begin
                                pop   = 1'b1;
                                n.sh  = rd_data;
                                n.st  = TX_DATA;
                                n.irq = last && !q.endm;
                            end else if (q.endm) begin
                                if (cfg_raw) begin
                                    n.st   = TX_IDLE;
                                    n.sh   = MARK_BYTE;
                                    n.go   = 1'b0;
                                    n.endm = 1'b0;
                                end else if (!cfg_no_crc) begin
                                    n.st     = TX_FCS;
                                    n.sh     = ~n.crc[7:0];
                                    n.fcs_hi = 1'b0;
                                end else begin
                                    n.st = TX_CLOSE;
                                    n.sh = FLAG_BYTE;
                                end
                            end else begin
                                n.st   = TX_ABORT;
                                n.sh   = ABORT_BYTE;
                                n.undr = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.sh   <= FLAG_BYTE;
            q.crc  <= CRC_INIT;
            q.txd  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign txd      = q.txd;
    assign irq      = q.irq;
    assign underrun = q.undr;

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
    parameter int SMALL_BLK = 16,
    parameter int BIG_BLK   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cmd_xmit,
    input  logic       cmd_end,
    input  logic       cmd_reset,
    input  logic       cfg_big_blk,
    input  logic       cfg_no_crc,
    input  logic       cfg_raw,
    output logic       txd,
    output logic       pool_irq,
    output logic       underrun
);
    logic [7:0] rd_data;
    logic       avail;
    logic       last;
    logic       pop;

    hdlc_tx_fifo #(
        .SMALL_BLK (SMALL_BLK),
        .BIG_BLK   (BIG_BLK)
    ) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cmd_reset),
        .big_blk (cfg_big_blk),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .commit  (cmd_xmit || cmd_end),
        .pop     (pop),
        .rd_data (rd_data),
        .avail   (avail),
        .last    (last)
    );

    hdlc_tx_serial i_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .cmd_xmit   (cmd_xmit),
        .cmd_end    (cmd_end),
        .cmd_reset  (cmd_reset),
        .cfg_no_crc (cfg_no_crc),
        .cfg_raw    (cfg_raw),
        .rd_data    (rd_data),
        .avail      (avail),
        .last       (last),
        .pop        (pop),
        .txd        (txd),
        .irq        (pool_irq),
        .underrun   (underrun)
    );

endmodule

// File: rtl/hdlc_tx_ctrl_chk.sv
module hdlc_tx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic cmd_reset,
    input logic txd,
    input logic pool_irq,
    input logic underrun
);
    AST_TXD_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));                               // R11
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pool_irq |=> !pool_irq);                                 // R6
    AST_IRQ_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pool_irq |-> $past(bit_en));                             // R6
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !cmd_reset) |=> underrun);                  // R8
    AST_RESET_CLEARS_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !underrun);                                // R9
    AST_RESET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !pool_irq);                                // R9
endmodule

bind hdlc_tx_ctrl hdlc_tx_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .cmd_reset (cmd_reset),
    .txd       (txd),
    .pool_irq  (pool_irq),
    .underrun  (underrun)
);

// File: tb/test_hdlc_tx_ctrl.sv
module test_hdlc_tx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_DIV    = 8;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] base;
        logic [7:0] step;
        logic       no_crc;
        logic       big;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1,  8'hA5, 8'h00, 1'b0, 1'b0},   // R2 single byte
        '{8'd8,  8'hFF, 8'h00, 1'b0, 1'b0},   // R4 all ones
        '{8'd12, 8'h7E, 8'h00, 1'b0, 1'b0},   // R4 flag-valued data
        '{8'd16, 8'h01, 8'h11, 1'b0, 1'b0},   // R5 full small block
        '{8'd32, 8'h3C, 8'h07, 1'b0, 1'b1},   // R5 full big block
        '{8'd10, 8'hF0, 8'h01, 1'b1, 1'b0}    // R3 no check sequence
    };

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
    logic wr_en = 1'b0, cmd_xmit = 1'b0, cmd_end = 1'b0, cmd_reset = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic cfg_big_blk = 1'b0, cfg_no_crc = 1'b0, cfg_raw = 1'b0;
    logic txd, pool_irq, underrun;

    int vectors = 0, miscompares = 0;
    int run = 0, nbits = 0, frames_done = 0, aborts = 0, flags_seen = 0;
    int bits_total = 0, irq_cnt = 0, glitches = 0, rx_len = 0, raw_n = 0, exp_n = 0;
    bit in_frame = 1'b0, raw_arm = 1'b0, raw_on = 1'b0;
    logic rx_bits [512];
    logic raw_bits [64];
    logic [7:0] rx_buf [80];
    logic [7:0] exp_buf [80];
    logic [15:0] last16 = 16'h0;

    hdlc_tx_ctrl i_hdlc_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_xmit(cmd_xmit), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
        .cfg_big_blk(cfg_big_blk), .cfg_no_crc(cfg_no_crc), .cfg_raw(cfg_raw),
        .txd(txd), .pool_irq(pool_irq), .underrun(underrun)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference line decoder: destuffs, finds flags and aborts
    task automatic take_bit(input logic b);
        bits_total++;
        last16 = {b, last16[15:1]};
        if (raw_arm && !raw_on && b == 1'b0) raw_on = 1'b1;
        if (raw_on && raw_n < 64) begin raw_bits[raw_n] = b; raw_n++; end
        if (b) begin
            run++;
            if (run == 7) begin aborts++; in_frame = 1'b0; nbits = 0; end
            else if (in_frame && nbits < 512) begin rx_bits[nbits] = 1'b1; nbits++; end
        end else begin
            if (run == 6) begin
                flags_seen++;
                if (in_frame && nbits >= 7) nbits -= 7;
                if (in_frame && nbits > 0 && nbits % 8 == 0 && nbits / 8 <= 80) begin
                    rx_len = nbits / 8;
                    for (int k = 0; k < rx_len; k++)
                        for (int j = 0; j < 8; j++) rx_buf[k][j] = rx_bits[8*k+j];
                    frames_done++;
                end
                in_frame = 1'b1;
                nbits = 0;
            end else if (run != 5) begin
                if (in_frame && nbits < 512) begin rx_bits[nbits] = 1'b0; nbits++; end
            end
            run = 0;
        end
    endtask

    // bit-enable generator and line monitor in one process
    initial begin
        int div = 0;
        logic prev_txd = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (bit_en) take_bit(txd);
                else if (txd !== prev_txd) glitches++;
                if (pool_irq) irq_cnt++;
            end
            prev_txd = txd;
            div = (div == BIT_DIV - 1) ? 0 : div + 1;
            bit_en = rst_n && (div == 0);
        end
    end

    task automatic wait_bits(input int nb);
        int t = bits_total + nb;
        while (bits_total < t) @(negedge clk);
    endtask

    task automatic write_seq(input logic [7:0] base, input logic [7:0] step, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = base + 8'(i) * step;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_xmit();  @(negedge clk); cmd_xmit  = 1'b1; @(negedge clk); cmd_xmit  = 1'b0; endtask
    task automatic pulse_end();   @(negedge clk); cmd_end   = 1'b1; @(negedge clk); cmd_end   = 1'b0; endtask
    task automatic pulse_reset(); @(negedge clk); cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0; endtask

    task automatic exp_push_seq(input logic [7:0] base, input logic [7:0] step, input int len);
        for (int i = 0; i < len; i++) begin exp_buf[exp_n] = base + 8'(i) * step; exp_n++; end
    endtask

    task automatic wait_frame(input int f0);
        int k = 0;
        while (frames_done == f0 && k < 20000) begin @(negedge clk); k++; end
    endtask

    // append the check sequence to the expected bytes, then compare with the decoder
    task automatic check_frame(input string req, input bit with_fcs);
        logic [15:0] c = 16'hFFFF;
        int bad = -1;
        if (with_fcs) begin
            for (int i = 0; i < exp_n; i++)
                for (int j = 0; j < 8; j++)
                    c = (c[0] ^ exp_buf[i][j]) ? ({1'b0, c[15:1]} ^ 16'h8408) : {1'b0, c[15:1]};
            c = ~c;
            exp_buf[exp_n] = c[7:0];  exp_n++;
            exp_buf[exp_n] = c[15:8]; exp_n++;
        end
        check(rx_len == exp_n, {req, " frame length"}, rx_len, exp_n);
        for (int i = 0; i < exp_n && i < rx_len; i++)
            if (bad < 0 && rx_buf[i] !== exp_buf[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else         check(1'b0, {req, " frame byte"}, rx_buf[bad], exp_buf[bad]);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int f0, a0, i0, fl0, k;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1,      "R1 reset txd",      txd, 1);
        check(pool_irq == 1'b0, "R1 reset pool_irq", pool_irq, 0);
        check(underrun == 1'b0, "R1 reset underrun", underrun, 0);
        rst_n = 1'b1;
        wait_bits(16);
        fl0 = flags_seen;
        wait_bits(80);
        check(flags_seen - fl0 == 10, "R1 idle flags in 80 bits", flags_seen - fl0, 10);

        // table of single-block frames
        for (int v = 0; v < NVEC; v++) begin
            cfg_big_blk = VECS[v].big;
            cfg_no_crc  = VECS[v].no_crc;
            f0 = frames_done; i0 = irq_cnt; exp_n = 0;
            write_seq(VECS[v].base, VECS[v].step, int'(VECS[v].len));
            pulse_end();
            wait_frame(f0);
            exp_push_seq(VECS[v].base, VECS[v].step, int'(VECS[v].len));
            check_frame(VECS[v].no_crc ? "R3 R2 vector" : "R2 R4 R5 vector", !VECS[v].no_crc);
            check(irq_cnt == i0, "R6 no irq for end block", irq_cnt - i0, 0);
            wait_bits(16);
        end
        cfg_no_crc = 1'b0; cfg_big_blk = 1'b0;

        // R5 writes beyond a small block are dropped
        f0 = frames_done; exp_n = 0;
        write_seq(8'h40, 8'h01, 20);
        pulse_end();
        wait_frame(f0);
        exp_push_seq(8'h40, 8'h01, 16);
        check_frame("R5 overflow dropped", 1'b1);
        wait_bits(16);

        // R7 R6 two-block frame continued after the pool interrupt
        f0 = frames_done; i0 = irq_cnt; exp_n = 0;
        write_seq(8'h10, 8'h03, 16);
        pulse_xmit();
        k = 0;
        while (irq_cnt == i0 && k < 5000) begin @(negedge clk); k++; end
        check(irq_cnt - i0 == 1, "R6 irq after first block", irq_cnt - i0, 1);
        write_seq(8'h40, 8'h03, 10);
        pulse_end();
        wait_frame(f0);
        exp_push_seq(8'h10, 8'h03, 16);
        exp_push_seq(8'h40, 8'h03, 10);
        check_frame("R7 continued frame", 1'b1);
        check(frames_done - f0 == 1, "R7 single frame", frames_done - f0, 1);
        check(irq_cnt - i0 == 1, "R6 no irq after end block", irq_cnt - i0, 1);
        wait_bits(16);

        // R8 underrun
        f0 = frames_done; a0 = aborts; i0 = irq_cnt;
        write_seq(8'h55, 8'h01, 3);
        pulse_xmit();
        k = 0;
        while (!underrun && k < 5000) begin @(negedge clk); k++; end
        check(underrun == 1'b1, "R8 underrun set", underrun, 1);
        check(irq_cnt - i0 == 1, "R6 irq before underrun", irq_cnt - i0, 1);
        wait_bits(24);
        check(aborts > a0, "R8 abort ones sent", aborts - a0, 1);
        check(frames_done == f0, "R8 no frame accepted", frames_done - f0, 0);
        check(underrun == 1'b1, "R8 underrun held", underrun, 1);

        // R9 reset clears underrun
        pulse_reset();
        check(underrun == 1'b0, "R9 underrun cleared", underrun, 0);
        wait_bits(24);

        // R9 reset aborts a frame in flight and empties the FIFO
        f0 = frames_done; a0 = aborts;
        write_seq(8'h20, 8'h05, 16);
        pulse_end();
        wait_bits(30);
        pulse_reset();
        fl0 = flags_seen;
        wait_bits(40);
        check(aborts > a0, "R9 abort on reset", aborts - a0, 1);
        check(frames_done == f0, "R9 aborted frame not accepted", frames_done - f0, 0);
        check(flags_seen - fl0 >= 2, "R9 flags resume", flags_seen - fl0, 2);
        f0 = frames_done; exp_n = 0;
        write_seq(8'hC3, 8'h11, 2);
        pulse_end();
        wait_frame(f0);
        exp_push_seq(8'hC3, 8'h11, 2);
        check_frame("R9 FIFO emptied by reset", 1'b1);
        wait_bits(16);

        // R10 raw mode
        cfg_raw = 1'b1;
        wait_bits(32);
        check(last16 == 16'hFFFF, "R10 raw idle ones", last16, 16'hFFFF);
        raw_n = 0; raw_on = 1'b0; raw_arm = 1'b1;
        exp_n = 0;
        exp_buf[0] = 8'h3C; exp_buf[1] = 8'hFF; exp_buf[2] = 8'h00; exp_buf[3] = 8'hF8;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = exp_buf[i];
        end
        @(negedge clk); wr_en = 1'b0;
        pulse_end();
        k = 0;
        while (raw_n < 48 && k < 5000) begin @(negedge clk); k++; end
        begin
            int bad = -1;
            for (int i = 0; i < 48; i++) begin
                logic e;
                e = (i < 32) ? exp_buf[i/8][i%8] : 1'b1;
                if (bad < 0 && raw_bits[i] !== e) bad = i;
            end
            check(bad < 0, "R10 raw bits", bad, -1);
        end
        raw_arm = 1'b0;
        cfg_raw = 1'b0;
        wait_bits(24);

        // R11 line only moves on bit ticks
        check(glitches == 0, "R11 txd stable between ticks", glitches, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule